// File: doc/BRIEF.md
# Mask-Selected Condition Code Evaluator

This block turns a data word and a bit mask into a 2-bit condition code. The mask picks which bits of the data word take part. In test mode the code tells whether the selected bits are all clear, all set, or mixed. In insert mode the code tells whether the selected field is zero, and if not, the state of its leading bit. Both modes work on the full 64-bit word or on its low 32-bit half.

When the selection is mixed, or when insert mode sees a nonzero selection, the result depends on one particular data bit. That bit is the one under the most significant set bit of the mask. A leading-one finder on the mask supplies its position. The decision logic itself is purely combinational. A parameter selects whether the code is registered before it leaves the block. The pipeline of the issuing unit places the block wherever it evaluates condition codes.

Top module: `mask_cond_eval`

## Requirements
- R1: When the masked data (data AND mask, within the active width) is zero, the code is 0 in both modes.
- R2: In test mode (mode_i = 0), with a nonzero mask whose selected data bits are all one, the code is 3.
- R3: In test mode at 32-bit width (wide_i = 0), any mixed selection (some selected bits one, some zero) gives code 1, whatever the leading bit is.
- R4: In test mode at 64-bit width (wide_i = 1), a mixed selection gives code 2 when the data bit under the most significant set mask bit is one, and code 1 when it is zero.
- R5: In insert mode (mode_i = 1), a nonzero selection gives code 1 when the data bit under the most significant set mask bit is one, and code 2 otherwise. This holds even when every selected bit is one, so insert mode never yields 3.
- R6: At 32-bit width, bits 63:32 of both data and mask have no effect on the code.
- R7: An all-zero mask gives code 0 in every mode and width combination.
- R8: With REG_OUT = 1 (the default), the code appears on cond_o at the first rising clock edge after the inputs are applied. It is 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| value_i | input | DW | Data word under test |
| mask_i | input | DW | Bit mask selecting the data bits that take part |
| mode_i | input | 1 | 0 = test mode, 1 = insert mode |
| wide_i | input | 1 | 1 = full width, 0 = low half only |
| cond_o | output | 2 | Condition code |

## Verification
A wrong leading-one position corrupts the code only in the mixed test case at full width and in insert mode. There it shows as a swap between codes 1 and 2, one clock after the vector is applied. For this reason the directed vectors put a single differing bit at the top of the mask and a set bit at the bottom. A stale or corrupted output register shows at once on the next vector, because every vector is checked at the edge after it is applied. The half-width narrowing is exposed by vectors whose only set bits lie in the upper half.

// File: rtl/mask_cond_pkg.sv
package mask_cond_pkg;

    typedef enum logic [1:0] {
        CC_ZERO  = 2'd0,
        CC_LOW   = 2'd1,
        CC_HIGH  = 2'd2,
        CC_FULL  = 2'd3
    } cc_e;

    typedef enum logic {
        MD_TEST   = 1'b0,
        MD_INSERT = 1'b1
    } mode_e;

    typedef struct packed {
        cc_e cond;
    } out_st_t;

endpackage

// File: rtl/mcc_lead_one.sv
module mcc_lead_one #(
    parameter int W  = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] pos_o,
    output logic          any_o
);
    // Scan upward; the highest set bit is the last one to write pos_o.
    always_comb begin
        pos_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                pos_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcc_decide.sv
module mcc_decide
    import mask_cond_pkg::*;
#(
    parameter int W  = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [W-1:0]  msk_i,
    input  logic [IW-1:0] lead_i,
    input  logic          mode_i,
    input  logic          wide_i,
    output cc_e           cond_o
);
    logic [W-1:0] sel;
    logic         lead_bit;

    always_comb begin
        sel      = val_i & msk_i;
        lead_bit = val_i[lead_i];
        if (sel == '0) begin
            cond_o = CC_ZERO;
        end else if (mode_i == MD_INSERT) begin
            cond_o = lead_bit ? CC_LOW : CC_HIGH;
        end else if (sel == msk_i) begin
            cond_o = CC_FULL;
        end else if (wide_i) begin
            cond_o = lead_bit ? CC_HIGH : CC_LOW;
        end else begin
            cond_o = CC_LOW;
        end
    end
endmodule

// File: rtl/mask_cond_eval.sv
module mask_cond_eval
    import mask_cond_pkg::*;
#(
    parameter int DW      = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] value_i,
    input  logic [DW-1:0] mask_i,
    input  logic          mode_i,
    input  logic          wide_i,
    output logic [1:0]    cond_o
);
    localparam int HW = DW / 2;
    localparam int IW = $clog2(DW);

    logic [DW-1:0] val_eff;
    logic [DW-1:0] msk_eff;
    logic [IW-1:0] lead_pos;
    logic          lead_any;
    cc_e           cc_raw;
    out_st_t       st_d;
    out_st_t       st_q;

    // Narrowing: the upper half is dropped when the low half is selected.
    always_comb begin
        val_eff = value_i;
        msk_eff = mask_i;
        if (!wide_i) begin
            val_eff[DW-1:HW] = '0;
            msk_eff[DW-1:HW] = '0;
        end
    end

    mcc_lead_one #(.W(DW)) u_lead (
        .vec_i (msk_eff),
        .pos_o (lead_pos),
        .any_o (lead_any)
    );

    mcc_decide #(.W(DW)) u_decide (
        .val_i  (val_eff),
        .msk_i  (msk_eff),
        .lead_i (lead_pos),
        .mode_i (mode_i),
        .wide_i (wide_i),
        .cond_o (cc_raw)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cond = lead_any ? cc_raw : CC_ZERO;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '{cond: CC_ZERO};
                end else begin
                    st_q <= st_d;
                end
            end
            assign cond_o = st_q.cond;
        end else begin : g_comb
            assign st_q   = '{cond: CC_ZERO};
            assign cond_o = st_d.cond;
        end
    endgenerate
endmodule

// File: rtl/mask_cond_eval_chk.sv
module mask_cond_eval_chk #(
    parameter int DW      = 64,
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] value_i,
    input logic [DW-1:0] mask_i,
    input logic          mode_i,
    input logic          wide_i,
    input logic [1:0]    cond_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] v_q, m_q;
    logic          md_q, wd_q, seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= '0;
            m_q    <= '0;
            md_q   <= 1'b0;
            wd_q   <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            v_q    <= value_i;
            m_q    <= mask_i;
            md_q   <= mode_i;
            wd_q   <= wide_i;
            seen_q <= 1'b1;
        end
    end

    logic [DW-1:0] ov, om, osel;
    logic          omd, owd, ok;

    always_comb begin
        ov  = REG_OUT ? v_q  : value_i;
        om  = REG_OUT ? m_q  : mask_i;
        omd = REG_OUT ? md_q : mode_i;
        owd = REG_OUT ? wd_q : wide_i;
        ok  = REG_OUT ? seen_q : 1'b1;
        if (!owd) begin
            ov[DW-1:HW] = '0;
            om[DW-1:HW] = '0;
        end
        osel = ov & om;
    end

    p_zero_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && osel == '0) |-> cond_o == 2'd0);

    p_all_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !omd && om != '0 && osel == om) |-> cond_o == 2'd3);

    p_narrow_mixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !omd && !owd && osel != '0 && osel != om) |-> cond_o == 2'd1);

    p_wide_mixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !omd && owd && osel != '0 && osel != om) |->
        (cond_o == 2'd1 || cond_o == 2'd2));

    p_insert_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && omd && osel != '0) |-> (cond_o == 2'd1 || cond_o == 2'd2));

    p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && om == '0) |-> cond_o == 2'd0);
endmodule

bind mask_cond_eval mask_cond_eval_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .value_i (value_i),
    .mask_i  (mask_i),
    .mode_i  (mode_i),
    .wide_i  (wide_i),
    .cond_o  (cond_o)
);

// File: tb/mask_cond_eval_test.sv
`timescale 1ns/1ps
module mask_cond_eval_test;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] value_i = '0;
    logic [DW-1:0] mask_i = '0;
    logic          mode_i = 1'b0;
    logic          wide_i = 1'b1;
    logic [1:0]    cond_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mask_cond_eval #(.DW(DW), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .value_i(value_i), .mask_i(mask_i),
        .mode_i(mode_i), .wide_i(wide_i), .cond_o(cond_o)
    );

    function automatic logic [1:0] model(input logic [DW-1:0] v, input logic [DW-1:0] m,
                                         input logic md, input logic wd);
        logic [DW-1:0] s;
        int top;
        if (!wd) begin
            v = v & {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
            m = m & {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
        end
        s = v & m;
        if (s == '0) return 2'd0;
        top = 0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (m[i]) begin top = i; break; end
        end
        if (md) return v[top] ? 2'd1 : 2'd2;
        if (s == m) return 2'd3;
        if (wd) return v[top] ? 2'd2 : 2'd1;
        return 2'd1;
    endfunction

    task automatic check(input logic [1:0] exp, input string req);
        n_vec++;
        if (cond_o !== exp) begin
            n_bad++;
            $display("FAIL %s: v=%h m=%h mode=%0d wide=%0d got %0d expected %0d",
                     req, value_i, mask_i, mode_i, wide_i, cond_o, exp);
        end
    endtask

    // Drive at a falling edge; the register captures at the next rising edge.
    task automatic apply(input logic [DW-1:0] v, input logic [DW-1:0] m,
                         input logic md, input logic wd,
                         input logic [1:0] exp, input string req);
        @(negedge clk);
        value_i = v; mask_i = m; mode_i = md; wide_i = wd;
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic t_reset_r8;
        rst_n = 1'b0;
        value_i = '1; mask_i = 64'hF; mode_i = 1'b0; wide_i = 1'b1;
        repeat (3) @(negedge clk);
        check(2'd0, "R8 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(2'd3, "R8 first edge");
        value_i = 64'h1; mask_i = 64'h100; mode_i = 1'b0;
        #1 check(2'd3, "R8 holds before edge");
        @(negedge clk);
        check(2'd0, "R8 next edge");
    endtask

    task automatic t_zero_sel_r1;
        apply(64'hFF00, 64'h00FF, 1'b0, 1'b1, 2'd0, "R1 test");
        apply(64'hFF00, 64'h00FF, 1'b1, 1'b1, 2'd0, "R1 insert");
        apply(64'hF0F0_0000, 64'h0F0F_0000, 1'b1, 1'b0, 2'd0, "R1 insert narrow");
    endtask

    task automatic t_all_set_r2;
        apply('1, 64'hF0F0_0000_0000_000F, 1'b0, 1'b1, 2'd3, "R2 wide");
        apply(64'hF0, 64'hF0, 1'b0, 1'b0, 2'd3, "R2 narrow");
    endtask

    task automatic t_narrow_mixed_r3;
        apply(64'h8000_0000, 64'h8000_0001, 1'b0, 1'b0, 2'd1, "R3 lead one");
        apply(64'h0000_0001, 64'h8000_0001, 1'b0, 1'b0, 2'd1, "R3 lead zero");
    endtask

    task automatic t_wide_mixed_r4;
        apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 1'b0, 1'b1, 2'd2, "R4 lead one");
        apply(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b0, 1'b1, 2'd1, "R4 lead zero");
        apply(64'h0000_0008_0000_0000, 64'h0000_000C_0000_0000, 1'b0, 1'b1, 2'd2, "R4 mid lead one");
    endtask

    task automatic t_insert_r5;
        apply(64'h0800, 64'h0F00, 1'b1, 1'b1, 2'd1, "R5 lead one");
        apply(64'h0100, 64'h0F00, 1'b1, 1'b1, 2'd2, "R5 lead zero");
        apply(64'hFF, 64'hFF, 1'b1, 1'b1, 2'd1, "R5 full selection");
        apply(64'h0001_0000, 64'h00FF_0000, 1'b1, 1'b0, 2'd2, "R5 narrow");
    endtask

    task automatic t_upper_ignored_r6;
        apply(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b0, 2'd0, "R6 upper only");
        apply(64'h0000_0000_0000_000F, 64'hFFFF_0000_0000_000F, 1'b0, 1'b0, 2'd3, "R6 upper mask");
        apply(64'h8000_0000_0000_0010, 64'h8000_0000_0000_0030, 1'b1, 1'b0, 2'd2, "R6 insert lead");
    endtask

    task automatic t_zero_mask_r7;
        for (int k = 0; k < 4; k++)
            apply('1, '0, k[0], k[1], 2'd0, "R7 zero mask");
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic [DW-1:0] v, m;
            logic md, wd;
            v  = {$urandom, $urandom};
            m  = {$urandom, $urandom};
            md = k[0];
            wd = k[1];
            if (k % 5 == 0) m = 64'h1 << (k % 64);
            if (k % 7 == 0) v = v | m;
            if (k % 11 == 0) m = m >> (k % 60);
            apply(v, m, md, wd, model(v, m, md, wd), "R4/R5 random vs model");
        end
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset_r8();
        t_zero_sel_r1();
        t_all_set_r2();
        t_narrow_mixed_r3();
        t_wide_mixed_r4();
        t_insert_r5();
        t_upper_ignored_r6();
        t_zero_mask_r7();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule